// File: doc/BRIEF.md
# Multiplexed LCD Scan Driver

This block scans a passive LCD panel of 40 segments by 8 commons at 1/8 duty with 1/4 bias. A CPU fills a small display memory through a byte-wide write port. The block steps through the commons one at a time, reads the matching row of display bits and turns every COM and SEG pin into a 3-bit drive-level code. The analog ladder downstream turns each code into one of five voltages. Because the polarity alternates between even and odd frames, the panel sees no net DC.

The memory gives each common five bytes on a stride of eight addresses. Common n owns addresses 8n to 8n+4, and the three addresses above them in each group hold nothing. A free-running 32.768 kHz enable pulse is divided by 64 to give the 512 Hz common step, so a full eight-common frame lasts 1/64 s. When the display is switched off, every pin is held at ground level and the scan restarts from the first common. The block also holds a 4-bit contrast value and passes it to the analog side unchanged.

Top module: `lcd_mux_scan`

## Requirements
- R1: After reset every COM and SEG output carries level code 0, the contrast output reads 0xF, and the scan is at COM0 in an even frame.
- R2: A write to address 8n+b, with b in 0..4 and n in 0..7, stores the data byte for common n. Bit k of that byte controls SEG(8b+k), so bit 0 of byte 0 is SEG0 and bit 7 of byte 4 is SEG39.
- R3: A write to any address whose low three bits are 5, 6 or 7 changes no stored bit and no output.
- R4: While on, the selected common carries code 4 in even frames and code 0 in odd frames. Every other common carries code 1 in even frames and code 3 in odd frames.
- R5: While on, a segment whose bit is 1 for the selected common carries code 0 in even frames and code 4 in odd frames. A segment whose bit is 0 carries code 2.
- R6: While the enable input is low, all outputs carry code 0 and the scan returns to COM0 in an even frame with the tick count cleared. Display writes made while off are still stored.
- R7: While on, the selected common advances by one after every 64th clock cycle in which the tick input is high. It does not change in any other cycle.
- R8: The frame parity toggles only when the scan wraps from COM7 to COM0.
- R9: A contrast write stores the 4-bit value, which appears on the contrast output from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | One-cycle pulse at 32.768 kHz |
| disp_on | input | 1 | Display enable |
| wr_en | input | 1 | Display memory write strobe |
| wr_addr | input | 6 | Display memory byte address |
| wr_data | input | 8 | Display memory write data |
| con_we | input | 1 | Contrast write strobe |
| con_data | input | 4 | Contrast write value |
| com_lvl | output | 24 | Drive code per common, 3 bits each, COM0 in bits 2:0 |
| seg_lvl | output | 120 | Drive code per segment, 3 bits each, SEG0 in bits 2:0 |
| con_lvl | output | 4 | Contrast value to the analog side |

## Verification
The drive codes are a pure function of the scan state and the stored row, so a fault shows on the pins in the same cycle it arises. A miscounted prescaler moves the code 4 marker to the wrong common on the 64th tick. A wrong parity flip swaps the codes of every pin in the next frame. A badly decoded address lights the wrong segment as soon as that common is scanned, which is at most one frame of 512 ticks later. The bench mixes directed walks across whole frames with long random runs of writes, enable changes and irregular ticks, and compares every pin against a model in every cycle.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   localparam int LVL_W = 3;
   typedef logic [LVL_W-1:0] lvl_t;

   localparam lvl_t LVL_GND  = 3'd0;
   localparam lvl_t LVL_1Q   = 3'd1;
   localparam lvl_t LVL_HALF = 3'd2;
   localparam lvl_t LVL_3Q   = 3'd3;
   localparam lvl_t LVL_TOP  = 3'd4;

   // common drive: selected line swings to a rail, the others sit near the opposite rail
   function automatic lvl_t com_drive(input logic sel, input logic odd);
      if (sel) return odd ? LVL_GND : LVL_TOP;
      return odd ? LVL_3Q : LVL_1Q;
   endfunction

   // segment drive: lit pixels oppose the selected common, dark ones stay mid-rail
   function automatic lvl_t seg_drive(input logic lit, input logic odd);
      if (lit) return odd ? LVL_TOP : LVL_GND;
      return LVL_HALF;
   endfunction

endpackage

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq #(
   parameter int NUM_COM  = 8,
   parameter int TICK_DIV = 64,
   localparam int COM_W   = $clog2(NUM_COM)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   output logic [COM_W-1:0] com_idx,
   output logic             frame_odd
);

   logic step;

   generate
      if (TICK_DIV == 1) begin : g_nodiv
         assign step = tick;
      end else begin : g_div
         localparam int PRE_W = $clog2(TICK_DIV);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
         logic [PRE_W-1:0] pre_cnt;

         always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
               pre_cnt <= '0;
            end else if (tick) begin
               if (pre_cnt == PRE_LAST) pre_cnt <= '0;
               else                     pre_cnt <= pre_cnt + 1'b1;
            end
         end

         assign step = tick && (pre_cnt == PRE_LAST);
      end
   endgenerate

   localparam logic [COM_W-1:0] COM_LAST = COM_W'(NUM_COM - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         com_idx   <= '0;
         frame_odd <= 1'b0;
      end else if (step) begin
         if (com_idx == COM_LAST) begin
            com_idx   <= '0;
            frame_odd <= ~frame_odd;
         end else begin
            com_idx <= com_idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
   parameter int NUM_COM  = 8,
   parameter int NUM_SEG  = 40,
   localparam int BYTES   = NUM_SEG / 8,
   localparam int STR_W   = (BYTES > 1) ? $clog2(BYTES) : 1,
   localparam int COM_W   = $clog2(NUM_COM),
   localparam int ADDR_W  = COM_W + STR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [7:0]         wr_data,
   input  logic [COM_W-1:0]   rd_com,
   output logic [NUM_SEG-1:0] rd_row
);

   logic [STR_W-1:0] wr_byte;
   logic [COM_W-1:0] wr_com;
   logic             com_ok;
   logic             byte_ok;

   assign wr_byte = wr_addr[STR_W-1:0];
   assign wr_com  = wr_addr[ADDR_W-1:STR_W];

   generate
      if (NUM_COM == (1 << COM_W)) begin : g_com_full
         assign com_ok = 1'b1;
      end else begin : g_com_part
         assign com_ok = (wr_com < COM_W'(NUM_COM));
      end
      if (BYTES == (1 << STR_W)) begin : g_byte_full
         assign byte_ok = 1'b1;
      end else begin : g_byte_part
         assign byte_ok = (wr_byte < STR_W'(BYTES));
      end
   endgenerate

   logic wr_hit;
   assign wr_hit = wr_en && com_ok && byte_ok;

   generate
      for (genvar c = 0; c < NUM_COM; c++) begin : g_row
         logic [NUM_SEG-1:0] row_q;
         for (genvar b = 0; b < BYTES; b++) begin : g_byte
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  row_q[b*8 +: 8] <= '0;
               end else if (wr_hit && (wr_com == COM_W'(c)) && (wr_byte == STR_W'(b))) begin
                  row_q[b*8 +: 8] <= wr_data;
               end
            end
         end
      end
   endgenerate

   // read mux over the rows
   logic [NUM_SEG-1:0] rows_flat [NUM_COM];
   generate
      for (genvar c = 0; c < NUM_COM; c++) begin : g_flat
         assign rows_flat[c] = g_row[c].row_q;
      end
   endgenerate

   always_comb begin
      rd_row = '0;
      for (int c = 0; c < NUM_COM; c++) begin
         if (rd_com == COM_W'(c)) rd_row = rows_flat[c];
      end
   end

endmodule

// File: rtl/lcd_lvl_enc.sv
module lcd_lvl_enc
   import lcd_scan_pkg::*;
#(
   parameter int NUM_COM = 8,
   parameter int NUM_SEG = 40,
   localparam int COM_W  = $clog2(NUM_COM)
) (
   input  logic                     on,
   input  logic [COM_W-1:0]         com_idx,
   input  logic                     frame_odd,
   input  logic [NUM_SEG-1:0]       row,
   output logic [NUM_COM*LVL_W-1:0] com_lvl,
   output logic [NUM_SEG*LVL_W-1:0] seg_lvl
);

   generate
      for (genvar i = 0; i < NUM_COM; i++) begin : g_com
         assign com_lvl[i*LVL_W +: LVL_W] =
            on ? com_drive(com_idx == COM_W'(i), frame_odd) : LVL_GND;
      end
      for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
         assign seg_lvl[j*LVL_W +: LVL_W] =
            on ? seg_drive(row[j], frame_odd) : LVL_GND;
      end
   endgenerate

endmodule

// File: rtl/lcd_mux_scan.sv
module lcd_mux_scan
   import lcd_scan_pkg::*;
#(
   parameter int NUM_COM  = 8,
   parameter int NUM_SEG  = 40,
   parameter int TICK_DIV = 64,
   parameter int CON_W    = 4,
   parameter int CON_RST  = 15,
   localparam int BYTES   = NUM_SEG / 8,
   localparam int STR_W   = (BYTES > 1) ? $clog2(BYTES) : 1,
   localparam int COM_W   = $clog2(NUM_COM),
   localparam int ADDR_W  = COM_W + STR_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick_in,
   input  logic                     disp_on,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [7:0]               wr_data,
   input  logic                     con_we,
   input  logic [CON_W-1:0]         con_data,
   output logic [NUM_COM*LVL_W-1:0] com_lvl,
   output logic [NUM_SEG*LVL_W-1:0] seg_lvl,
   output logic [CON_W-1:0]         con_lvl
);

   generate
      if (NUM_SEG % 8 != 0 || NUM_SEG < 8) begin : g_bad_seg
         $error("NUM_SEG must be a positive multiple of 8");
      end
      if (NUM_COM < 2) begin : g_bad_com
         $error("NUM_COM must be at least 2");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (CON_RST >= (1 << CON_W) || CON_RST < 0) begin : g_bad_con
         $error("CON_RST does not fit in CON_W bits");
      end
   endgenerate

   logic [COM_W-1:0]   com_idx;
   logic               frame_odd;
   logic [NUM_SEG-1:0] cur_row;

   lcd_scan_seq #(
      .NUM_COM  (NUM_COM),
      .TICK_DIV (TICK_DIV)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (disp_on),
      .tick      (tick_in),
      .com_idx   (com_idx),
      .frame_odd (frame_odd)
   );

   lcd_disp_ram #(
      .NUM_COM (NUM_COM),
      .NUM_SEG (NUM_SEG)
   ) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_com  (com_idx),
      .rd_row  (cur_row)
   );

   lcd_lvl_enc #(
      .NUM_COM (NUM_COM),
      .NUM_SEG (NUM_SEG)
   ) u_enc (
      .on        (disp_on),
      .com_idx   (com_idx),
      .frame_odd (frame_odd),
      .row       (cur_row),
      .com_lvl   (com_lvl),
      .seg_lvl   (seg_lvl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      con_lvl <= CON_W'(CON_RST);
      else if (con_we) con_lvl <= con_data;
   end

endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
   parameter int NUM_COM = 8,
   parameter int NUM_SEG = 40,
   parameter int CON_W   = 4,
   parameter int CON_RST = 15,
   localparam int COM_W  = $clog2(NUM_COM)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 disp_on,
   input logic                 tick_in,
   input logic [COM_W-1:0]     com_sel,
   input logic                 frame_odd,
   input logic [NUM_COM*3-1:0] com_lvl,
   input logic [NUM_SEG*3-1:0] seg_lvl,
   input logic [CON_W-1:0]     con_lvl
);

   localparam logic [COM_W-1:0] COM_LAST = COM_W'(NUM_COM - 1);

   logic [NUM_COM-1:0] sel_hit;
   logic [NUM_COM-1:0] com_ok;
   logic [NUM_SEG-1:0] seg_ok;

   generate
      for (genvar i = 0; i < NUM_COM; i++) begin : g_c
         logic [2:0] v;
         assign v          = com_lvl[i*3 +: 3];
         assign sel_hit[i] = (v == (frame_odd ? 3'd0 : 3'd4));
         assign com_ok[i]  = sel_hit[i] || (v == (frame_odd ? 3'd3 : 3'd1));
      end
      for (genvar j = 0; j < NUM_SEG; j++) begin : g_s
         logic [2:0] v;
         assign v         = seg_lvl[j*3 +: 3];
         assign seg_ok[j] = (v == 3'd2) || (v == (frame_odd ? 3'd4 : 3'd0));
      end
   endgenerate

   function automatic logic [COM_W-1:0] nxt(input logic [COM_W-1:0] c);
      return (c == COM_LAST) ? '0 : c + 1'b1;
   endfunction

   p_con_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> con_lvl == CON_W'(CON_RST));

   p_one_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      disp_on |-> ($countones(sel_hit) == 1 && (&com_ok)));

   p_seg_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      disp_on |-> (&seg_ok));

   p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_on |-> (com_lvl == '0 && seg_lvl == '0));

   p_off_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_on |=> (com_sel == '0 && !frame_odd));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_on && !tick_in) |=> ($stable(com_sel) && $stable(frame_odd)));

   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_on && tick_in) |=> (com_sel == $past(com_sel) || com_sel == nxt($past(com_sel))));

   p_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_on && com_sel != COM_LAST) |=> $stable(frame_odd));

endmodule

bind lcd_mux_scan lcd_scan_chk #(
   .NUM_COM (NUM_COM),
   .NUM_SEG (NUM_SEG),
   .CON_W   (CON_W),
   .CON_RST (CON_RST)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .disp_on   (disp_on),
   .tick_in   (tick_in),
   .com_sel   (com_idx),
   .frame_odd (frame_odd),
   .com_lvl   (com_lvl),
   .seg_lvl   (seg_lvl),
   .con_lvl   (con_lvl)
);

// File: tb/sim_lcd_mux_scan.sv
`timescale 1ns/1ps
module sim_lcd_mux_scan;

   localparam int NC = 8;
   localparam int NS = 40;
   localparam int DIV = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_in = 1'b0;
   logic         disp_on = 1'b0;
   logic         wr_en = 1'b0;
   logic [5:0]   wr_addr = '0;
   logic [7:0]   wr_data = '0;
   logic         con_we = 1'b0;
   logic [3:0]   con_data = '0;
   logic [NC*3-1:0] com_lvl;
   logic [NS*3-1:0] seg_lvl;
   logic [3:0]   con_lvl;

   always #2 clk = ~clk;

   lcd_mux_scan u0 (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .disp_on(disp_on),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .con_we(con_we), .con_data(con_data),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl), .con_lvl(con_lvl)
   );

   // ---------------- reference model ----------------
   logic [7:0] m_ram [NC][5];
   int         m_cnt;
   int         m_com;
   bit         m_odd;
   logic [3:0] m_con;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NC; c++)
            for (int b = 0; b < 5; b++) m_ram[c][b] <= 8'h00;
         m_cnt <= 0; m_com <= 0; m_odd <= 1'b0; m_con <= 4'hF;
      end else begin
         if (wr_en && wr_addr[2:0] < 3'd5) m_ram[wr_addr[5:3]][wr_addr[2:0]] <= wr_data;
         if (con_we) m_con <= con_data;
         if (!disp_on) begin
            m_cnt <= 0; m_com <= 0; m_odd <= 1'b0;
         end else if (tick_in) begin
            if (m_cnt == DIV-1) begin
               m_cnt <= 0;
               if (m_com == NC-1) begin m_com <= 0; m_odd <= ~m_odd; end
               else m_com <= m_com + 1;
            end else m_cnt <= m_cnt + 1;
         end
      end
   end

   function automatic logic [NC*3-1:0] exp_com();
      logic [NC*3-1:0] v = '0;
      for (int i = 0; i < NC; i++) begin
         if (!rst_n || !disp_on) v[i*3 +: 3] = 3'd0;
         else if (i == m_com)    v[i*3 +: 3] = m_odd ? 3'd0 : 3'd4;
         else                    v[i*3 +: 3] = m_odd ? 3'd3 : 3'd1;
      end
      return v;
   endfunction

   function automatic logic [NS*3-1:0] exp_seg();
      logic [NS*3-1:0] v = '0;
      for (int j = 0; j < NS; j++) begin
         logic lit;
         lit = m_ram[m_com][j/8][j%8];
         if (!rst_n || !disp_on) v[j*3 +: 3] = 3'd0;
         else if (lit)           v[j*3 +: 3] = m_odd ? 3'd4 : 3'd0;
         else                    v[j*3 +: 3] = 3'd2;
      end
      return v;
   endfunction

   // ---------------- checking ----------------
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   task automatic check_all(input string tag);
      logic [NC*3-1:0] ec;
      logic [NS*3-1:0] es;
      ec = exp_com();
      es = exp_seg();
      n_cmp++;
      if (com_lvl !== ec) begin
         n_bad++;
         $display("FAIL %s com_lvl act=%h exp=%h", tag, com_lvl, ec);
      end
      n_cmp++;
      if (seg_lvl !== es) begin
         n_bad++;
         $display("FAIL %s seg_lvl act=%h exp=%h", tag, seg_lvl, es);
      end
      n_cmp++;
      if (con_lvl !== m_con) begin
         n_bad++;
         $display("FAIL %s con_lvl act=%h exp=%h", tag, con_lvl, m_con);
      end
   endtask

   task automatic check_val(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic int com_at(input int i);
      return int'(com_lvl[i*3 +: 3]);
   endfunction
   function automatic int seg_at(input int j);
      return int'(seg_lvl[j*3 +: 3]);
   endfunction

   task automatic idle();
      wr_en = 0; con_we = 0; tick_in = 0;
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1; wr_addr = 6'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic ticks(input int n);
      tick_in = 1;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check_all("R7");
      end
      tick_in = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1: reset state
      check_all("R1");
      check_val("R1 contrast", int'(con_lvl), 15);
      rst_n = 1;
      @(negedge clk);
      check_all("R1");
      check_val("R1 com0 blank", com_at(0), 0);

      // R2 / R3: mapping, written while off (R6 keeps storage)
      wr(0, 8'h01);
      wr(4, 8'h80);
      wr(5, 8'hFF);
      wr(7, 8'hFF);
      wr(8, 8'h02);
      disp_on = 1;
      @(negedge clk);
      check_all("R2");
      check_val("R2 seg0 lit", seg_at(0), 0);
      check_val("R2 seg39 lit", seg_at(39), 0);
      for (int j = 1; j < 39; j++) check_val("R3 unlit seg", seg_at(j), 2);
      check_val("R4 sel com0 even", com_at(0), 4);
      check_val("R4 nonsel com5 even", com_at(5), 1);

      // R7: 63 ticks keep COM0, 64th moves to COM1
      ticks(DIV-1);
      check_val("R7 still com0", com_at(0), 4);
      ticks(1);
      check_val("R7 com1 selected", com_at(1), 4);
      check_val("R2 seg1 on com1", seg_at(1), 0);
      check_val("R5 seg0 dark on com1", seg_at(0), 2);

      // R8: wrap into odd frame
      ticks(DIV*(NC-1));
      check_val("R8 com0 odd", com_at(0), 0);
      check_val("R4 nonsel odd", com_at(3), 3);
      check_val("R5 seg0 lit odd", seg_at(0), 4);
      ticks(DIV*NC);
      check_val("R8 back to even", com_at(0), 4);

      // R6: off blanks and clears; writes still land. R9 contrast.
      disp_on = 0;
      @(negedge clk);
      check_all("R6");
      check_val("R6 com blank", com_at(0), 0);
      check_val("R6 seg blank", seg_at(0), 0);
      wr(12, 8'h80);
      con_we = 1; con_data = 4'h3;
      @(negedge clk);
      con_we = 0;
      check_val("R9 contrast", int'(con_lvl), 3);
      disp_on = 1;
      @(negedge clk);
      check_all("R6");
      check_val("R6 restart com0", com_at(0), 4);
      ticks(DIV);
      check_val("R6 write while off", seg_at(39), 0);

      // random phase
      for (int n = 0; n < 30000; n++) begin
         tick_in  = ($urandom_range(0, 2) != 0);
         disp_on  = ($urandom_range(0, 199) != 0);
         wr_en    = ($urandom_range(0, 3) == 0);
         wr_addr  = 6'($urandom_range(0, 63));
         wr_data  = 8'($urandom_range(0, 255));
         con_we   = ($urandom_range(0, 15) == 0);
         con_data = 4'($urandom_range(0, 15));
         @(negedge clk);
         check_all("R4");
      end
      idle();
      @(negedge clk);
      check_all("R5");
      finish_run();
   end

endmodule